// File: doc/BRIEF.md
# Sensor Code to Millidegree Converter

This block turns a raw reading from an on-die temperature sensor ADC into a signed temperature in millidegrees Celsius. It holds a breakpoint table of code and temperature pairs, one pair every 5000 millidegrees from -40000 to 125000. A build-time parameter selects one of two table flavours: a falling table, where the code drops as the die heats (12-bit data), or a rising table, where the code climbs with temperature (10-bit data).

A conversion begins when a code arrives with its valid strobe. The block masks the code to the table's data width and rejects codes that lie outside the table's usable range. It then binary-searches for the pair of breakpoints that bracket the code, one iteration per clock. It finishes with a linear interpolation between those breakpoints, using a bit-serial divide that truncates. One done pulse reports the result, and an invalid flag marks a rejected code. Only one conversion runs at a time.

Top module: `thermconv`

## Requirements
- R1: After reset, `conv_done_o` and `conv_invalid_o` are 0 and `temp_mdeg_o` is 0.
- R2: Only the low data-width bits of `sample_code_i` take part: 12 bits for the falling table and 10 bits for the rising table. Higher bits have no effect on the result.
- R3: A masked code is rejected with one done pulse, `conv_invalid_o` = 1 and `temp_mdeg_o` = 0 in that case: below 3421 for the falling table, or below 106 for the rising table.
- R4: Breakpoint i (1..34) has temperature -40000 + 5000*(i-1). The falling-table codes for i = 1..34 are 3800 3792 3783 3774 3765 3756 3747 3737 3728 3718 3708 3698 3688 3678 3667 3656 3645 3634 3623 3611 3600 3588 3575 3563 3550 3537 3524 3510 3496 3482 3467 3452 3437 3421. The rising-table codes are 104+2i for i = 1..29 and 163+2(i-30) for i = 30..34. A code equal to a breakpoint code yields that breakpoint's temperature.
- R5: A code strictly between breakpoints i-1 and i yields T(i-1) + 5000*|C(i-1)-code| / |C(i-1)-C(i)|, where the divide truncates toward zero.
- R6: On the falling table, codes from 3800 up to the all-ones value give -40000. On the rising table, codes from 171 up to the all-ones value give 125000.
- R7: `conv_done_o` is high for a single cycle per conversion. `conv_invalid_o` is only ever high together with `conv_done_o`.
- R8: `temp_mdeg_o` changes only in a cycle where `conv_done_o` is high, and holds its value between results.
- R9: A valid strobe that arrives while a conversion is in progress is dropped. It produces no result and does not alter the running one.
- R10: Every accepted (not rejected) result lies in -40000..125000.
- R11: Parameter `ASCENDING` selects the table: 0 for the falling table and 1 for the rising table. Both flavours follow R2 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe: a new code is present |
| sample_code_i | input | IN_W | Raw ADC code |
| temp_mdeg_o | output | TEMP_W | Signed temperature in millidegrees |
| conv_done_o | output | 1 | One-cycle result strobe |
| conv_invalid_o | output | 1 | Code rejected (valid with done) |

## Verification
The checks assume `sample_valid_i` is only meaningful when the block is idle. They also assume that a code outside the table's valid band never reaches the divider, so the divisor is always a nonzero breakpoint gap. The stimulus waits for each done pulse before it sends the next code, except in the deliberate overlap cases. Those cases inject a second strobe mid-search and expect it to vanish. The sweeps cover the whole valid band, both rejection edges and the all-ones saturation codes. The random upper input bits exercise the masking.

// File: rtl/thermconv_pkg.sv
package thermconv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DIVIDE = 2'd2,
        ST_FLAG   = 2'd3
    } conv_state_e;

    localparam int STEP_MDEG    = 5000;
    localparam int COLD_MDEG    = -40000;
    localparam int REAL_ENTRIES = 34;

    // Breakpoint code at index idx; index 0 and the last index are sentinels.
    function automatic int tbl_code(int asc, int idx);
        if (asc != 0) begin
            if (idx <= 0)  return 0;
            if (idx >= 35) return 1023;
            if (idx <= 29) return 104 + 2 * idx;
            return 163 + 2 * (idx - 30);
        end
        case (idx)
            0:  return 4095;
            1:  return 3800;  2:  return 3792;  3:  return 3783;  4:  return 3774;
            5:  return 3765;  6:  return 3756;  7:  return 3747;  8:  return 3737;
            9:  return 3728;  10: return 3718;  11: return 3708;  12: return 3698;
            13: return 3688;  14: return 3678;  15: return 3667;  16: return 3656;
            17: return 3645;  18: return 3634;  19: return 3623;  20: return 3611;
            21: return 3600;  22: return 3588;  23: return 3575;  24: return 3563;
            25: return 3550;  26: return 3537;  27: return 3524;  28: return 3510;
            29: return 3496;  30: return 3482;  31: return 3467;  32: return 3452;
            33: return 3437;  34: return 3421;
            default: return 0;
        endcase
    endfunction

    // Breakpoint temperature: sentinels repeat the neighbouring end value.
    function automatic int tbl_temp(int idx);
        int k;
        k = idx - 1;
        if (k < 0) k = 0;
        if (k > REAL_ENTRIES - 1) k = REAL_ENTRIES - 1;
        return COLD_MDEG + STEP_MDEG * k;
    endfunction

endpackage

// File: rtl/thermconv_table.sv
module thermconv_table
    import thermconv_pkg::*;
#(
    parameter int ASCENDING = 0,
    parameter int IDX_W     = 6,
    parameter int CODE_W    = 12,
    parameter int TEMP_W    = 32
) (
    input  logic [IDX_W-1:0]         idx_i,
    output logic [CODE_W-1:0]        code_o,
    output logic signed [TEMP_W-1:0] temp_o
);

    always_comb begin
        code_o = CODE_W'(tbl_code(ASCENDING, int'(idx_i)));
        temp_o = TEMP_W'(tbl_temp(int'(idx_i)));
    end

endmodule

// File: rtl/thermconv_div.sv
module thermconv_div #(
    parameter int W     = 25,
    parameter int DVS_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [W-1:0]     dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic [W-1:0]     quotient_o,
    output logic             done_o
);

    localparam int CNT_W = $clog2(W);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DVS_W-1:0] rem;
        logic [W-1:0]     quo;
        logic [DVS_W-1:0] dvs;
    } div_t;

    div_t            div_d, div_q;
    logic [DVS_W:0]  shifted;
    logic            qbit;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        shifted    = {div_q.rem, div_q.quo[W-1]};
        qbit       = 1'b0;
        if (start_i) begin
            div_d.busy = 1'b1;
            div_d.cnt  = '0;
            div_d.rem  = '0;
            div_d.quo  = dividend_i;
            div_d.dvs  = divisor_i;
        end else if (div_q.busy) begin
            if (shifted >= {1'b0, div_q.dvs}) begin
                qbit      = 1'b1;
                div_d.rem = DVS_W'(shifted - {1'b0, div_q.dvs});
            end else begin
                div_d.rem = shifted[DVS_W-1:0];
            end
            div_d.quo = {div_q.quo[W-2:0], qbit};
            if (div_q.cnt == CNT_W'(W - 1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    assign quotient_o = div_q.quo;
    assign done_o     = div_q.done;

endmodule

// File: rtl/thermconv.sv
module thermconv
    import thermconv_pkg::*;
#(
    parameter int ASCENDING = 0,
    parameter int IN_W      = 16,
    parameter int TEMP_W    = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sample_valid_i,
    input  logic [IN_W-1:0]          sample_code_i,
    output logic signed [TEMP_W-1:0] temp_mdeg_o,
    output logic                     conv_done_o,
    output logic                     conv_invalid_o
);

    localparam int DATA_W     = (ASCENDING != 0) ? 10 : 12;
    localparam int ENTRIES    = (ASCENDING != 0) ? 36 : 35;
    localparam int LAST_IDX   = ENTRIES - 1;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int SUM_W      = IDX_W + 1;
    localparam int STEP_W     = 13;
    localparam int NUM_W      = DATA_W + STEP_W;
    localparam int FLOOR_CODE = (ASCENDING != 0) ? tbl_code(ASCENDING, 1)
                                                 : tbl_code(ASCENDING, LAST_IDX);

    typedef struct packed {
        conv_state_e              state;
        logic [IDX_W-1:0]         lo;
        logic [IDX_W-1:0]         hi;
        logic [DATA_W-1:0]        code;
        logic signed [TEMP_W-1:0] base;
        logic signed [TEMP_W-1:0] temp;
        logic                     done;
        logic                     invalid;
    } conv_t;

    conv_t                    conv_d, conv_q;
    logic [DATA_W-1:0]        masked;
    logic [SUM_W-1:0]         idx_sum;
    logic [IDX_W-1:0]         mid, prev_idx;
    logic [DATA_W-1:0]        code_mid, code_prev, span_code, den;
    logic signed [TEMP_W-1:0] temp_mid, temp_prev;
    logic [STEP_W-1:0]        step;
    logic [NUM_W-1:0]         num;
    logic                     go_hi, div_start, div_done;
    logic [NUM_W-1:0]         div_quo;

    assign masked   = sample_code_i[DATA_W-1:0];
    assign idx_sum  = {1'b0, conv_q.lo} + {1'b0, conv_q.hi};
    assign mid      = idx_sum[SUM_W-1:1];
    assign prev_idx = mid - 1'b1;

    thermconv_table #(.ASCENDING(ASCENDING), .IDX_W(IDX_W), .CODE_W(DATA_W), .TEMP_W(TEMP_W))
        u_tbl_mid (.idx_i(mid), .code_o(code_mid), .temp_o(temp_mid));

    thermconv_table #(.ASCENDING(ASCENDING), .IDX_W(IDX_W), .CODE_W(DATA_W), .TEMP_W(TEMP_W))
        u_tbl_prev (.idx_i(prev_idx), .code_o(code_prev), .temp_o(temp_prev));

    generate
        if (ASCENDING != 0) begin : g_rising
            assign go_hi     = code_mid > conv_q.code;
            assign span_code = conv_q.code - code_prev;
            assign den       = code_mid - code_prev;
        end else begin : g_falling
            assign go_hi     = code_mid <= conv_q.code;
            assign span_code = code_prev - conv_q.code;
            assign den       = code_prev - code_mid;
        end
    endgenerate

    assign step = STEP_W'(temp_mid - temp_prev);
    assign num  = NUM_W'(step) * NUM_W'(span_code);

    thermconv_div #(.W(NUM_W), .DVS_W(DATA_W)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (div_start),
        .dividend_i (num),
        .divisor_i  (den),
        .quotient_o (div_quo),
        .done_o     (div_done)
    );

    always_comb begin
        conv_d         = conv_q;
        conv_d.done    = 1'b0;
        conv_d.invalid = 1'b0;
        div_start      = 1'b0;
        case (conv_q.state)
            ST_IDLE: begin
                if (sample_valid_i) begin
                    conv_d.code = masked;
                    if (masked < DATA_W'(FLOOR_CODE)) begin
                        conv_d.state = ST_FLAG;
                    end else begin
                        conv_d.lo    = IDX_W'(1);
                        conv_d.hi    = IDX_W'(LAST_IDX);
                        conv_d.state = ST_SEARCH;
                    end
                end
            end
            ST_FLAG: begin
                conv_d.state   = ST_IDLE;
                conv_d.done    = 1'b1;
                conv_d.invalid = 1'b1;
                conv_d.temp    = '0;
            end
            ST_SEARCH: begin
                if (conv_q.lo == conv_q.hi) begin
                    div_start    = 1'b1;
                    conv_d.base  = temp_prev;
                    conv_d.state = ST_DIVIDE;
                end else if (go_hi) begin
                    conv_d.hi = mid;
                end else begin
                    conv_d.lo = mid + 1'b1;
                end
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    conv_d.temp  = conv_q.base + TEMP_W'(div_quo);
                    conv_d.done  = 1'b1;
                    conv_d.state = ST_IDLE;
                end
            end
            default: conv_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) conv_q <= '0;
        else         conv_q <= conv_d;
    end

    assign temp_mdeg_o    = conv_q.temp;
    assign conv_done_o    = conv_q.done;
    assign conv_invalid_o = conv_q.invalid;

endmodule

// File: rtl/thermconv_chk.sv
module thermconv_chk #(
    parameter int TEMP_W = 32
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     done_i,
    input logic                     invalid_i,
    input logic signed [TEMP_W-1:0] temp_i
);

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i); // R7

    AST_INVALID_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        invalid_i |-> done_i); // R7

    AST_REJECT_ZERO_TEMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        invalid_i |-> (temp_i == '0)); // R3

    AST_RESULT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !invalid_i) |-> (temp_i >= -40000 && temp_i <= 125000)); // R10

    AST_TEMP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(temp_i) |-> done_i); // R8

endmodule

bind thermconv thermconv_chk #(.TEMP_W(TEMP_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (conv_done_o),
    .invalid_i (conv_invalid_o),
    .temp_i    (temp_mdeg_o)
);

// File: tb/thermconv_test.sv
module thermconv_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        dsc_valid, inc_valid;
    logic [15:0] dsc_code, inc_code;
    logic signed [31:0] dsc_temp, inc_temp;
    logic        dsc_done, dsc_inv, inc_done, inc_inv;

    int vectors = 0;
    int miscompares = 0;
    int got [2];
    int sent [2];
    int    exp_t [2][$];
    bit    exp_i [2][$];
    string exp_tag [2][$];

    thermconv #(.ASCENDING(0)) uut (
        .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(dsc_valid), .sample_code_i(dsc_code),
        .temp_mdeg_o(dsc_temp), .conv_done_o(dsc_done), .conv_invalid_o(dsc_inv));

    thermconv #(.ASCENDING(1)) uut_inc (
        .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(inc_valid), .sample_code_i(inc_code),
        .temp_mdeg_o(inc_temp), .conv_done_o(inc_done), .conv_invalid_o(inc_inv));

    function automatic int fall_code(int i);
        case (i)
            1: return 3800;  2: return 3792;  3: return 3783;  4: return 3774;  5: return 3765;
            6: return 3756;  7: return 3747;  8: return 3737;  9: return 3728;  10: return 3718;
            11: return 3708; 12: return 3698; 13: return 3688; 14: return 3678; 15: return 3667;
            16: return 3656; 17: return 3645; 18: return 3634; 19: return 3623; 20: return 3611;
            21: return 3600; 22: return 3588; 23: return 3575; 24: return 3563; 25: return 3550;
            26: return 3537; 27: return 3524; 28: return 3510; 29: return 3496; 30: return 3482;
            31: return 3467; 32: return 3452; 33: return 3437; 34: return 3421;
            default: return 0;
        endcase
    endfunction

    function automatic int rise_code(int i);
        return (i <= 29) ? 104 + 2 * i : 163 + 2 * (i - 30);
    endfunction

    function automatic int bp_temp(int i);
        return -40000 + 5000 * (i - 1);
    endfunction

    function automatic int model(bit asc, int raw, output bit inv);
        int c;
        inv = 1'b0;
        if (asc) begin
            c = raw & 'h3FF;
            if (c < 106) begin inv = 1'b1; return 0; end
            if (c >= 171) return 125000;
            for (int i = 2; i <= 34; i++)
                if (c < rise_code(i))
                    return bp_temp(i-1) + 5000 * (c - rise_code(i-1)) / (rise_code(i) - rise_code(i-1));
        end else begin
            c = raw & 'hFFF;
            if (c < 3421) begin inv = 1'b1; return 0; end
            if (c >= 3800) return -40000;
            for (int i = 2; i <= 34; i++)
                if (c >= fall_code(i))
                    return bp_temp(i-1) + 5000 * (fall_code(i-1) - c) / (fall_code(i-1) - fall_code(i));
        end
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(bit asc, int raw, bit on);
        if (asc) begin inc_valid = on; inc_code = 16'(raw); end
        else     begin dsc_valid = on; dsc_code = 16'(raw); end
    endtask

    task automatic push(bit asc, int raw, string tag);
        bit inv;
        int t;
        t = model(asc, raw, inv);
        exp_t[asc].push_back(t);
        exp_i[asc].push_back(inv);
        exp_tag[asc].push_back(tag);
        sent[asc]++;
    endtask

    task automatic wait_drain(bit asc);
        while (exp_t[asc].size() != 0) @(negedge clk);
    endtask

    task automatic send(bit asc, int raw, string tag);
        push(asc, raw, tag);
        @(negedge clk);
        drive(asc, raw, 1'b1);
        @(negedge clk);
        drive(asc, 0, 1'b0);
        wait_drain(asc);
    endtask

    // Scoreboard monitors
    task automatic observe(bit asc, logic done, logic inv, int temp);
        if (inv && !done) begin
            vectors++; miscompares++;
            $display("FAIL R7: actual invalid=1 without done, expected invalid=0");
        end
        if (done) begin
            got[asc]++;
            if (exp_t[asc].size() == 0) begin
                vectors++; miscompares++;
                $display("FAIL R9: actual unexpected result %0d, expected no result", temp);
            end else begin
                string tag;
                int    et;
                bit    ei;
                et  = exp_t[asc].pop_front();
                ei  = exp_i[asc].pop_front();
                tag = exp_tag[asc].pop_front();
                check(tag, temp, et);
                check({tag, " invalid flag R3"}, int'(inv), int'(ei));
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            observe(1'b0, dsc_done, dsc_inv, dsc_temp);
            observe(1'b1, inc_done, inc_inv, inc_temp);
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog: actual still running, expected finished");
        summary();
        $finish;
    end

    initial begin
        got[0] = 0; got[1] = 0; sent[0] = 0; sent[1] = 0;
        rst_n = 1'b0;
        dsc_valid = 1'b0; inc_valid = 1'b0; dsc_code = '0; inc_code = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", int'(dsc_done), 0);
        check("R1 invalid", int'(dsc_inv), 0);
        check("R1 temp", dsc_temp, 0);
        check("R1 done rising", int'(inc_done), 0);
        check("R1 temp rising", inc_temp, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: exact breakpoints, both flavours (R11)
        for (int i = 1; i <= 34; i++) send(1'b0, fall_code(i), "R4 falling");
        for (int i = 1; i <= 34; i++) send(1'b1, rise_code(i), "R4 R11 rising");

        // R5: interpolation sweep across the valid band
        for (int c = 3422; c < 3800; c += 7) send(1'b0, c, "R5 falling");
        for (int c = 107; c < 171; c++) send(1'b1, c, "R5 R11 rising");

        // R3: rejection edges
        send(1'b0, 3420, "R3 falling edge");
        send(1'b0, 0, "R3 falling zero");
        send(1'b1, 105, "R3 rising edge");
        send(1'b1, 0, "R3 rising zero");

        // R6: saturation at the open ends
        send(1'b0, 3801, "R6 falling");
        send(1'b0, 4095, "R6 falling all-ones");
        send(1'b1, 172, "R6 rising");
        send(1'b1, 1023, "R6 rising all-ones");

        // R2: upper bits are masked away
        send(1'b0, 'hA000 + 3700, "R2 falling");
        send(1'b0, 'h5000 + 3000, "R2 falling reject");
        send(1'b1, 'hFC00 + 120, "R2 rising");
        send(1'b1, 'h0800 + 150, "R2 rising");

        // R8: result holds after the done pulse
        send(1'b0, 3600, "R8 setup");
        repeat (20) @(negedge clk);
        check("R8 hold", dsc_temp, 60000);

        // R9: strobe during a busy conversion is dropped
        push(1'b0, 3600, "R9 first");
        @(negedge clk); drive(1'b0, 3600, 1'b1);
        @(negedge clk); drive(1'b0, 0, 1'b0);
        repeat (3) @(negedge clk);
        drive(1'b0, 3421, 1'b1);
        @(negedge clk); drive(1'b0, 0, 1'b0);
        wait_drain(1'b0);
        repeat (50) @(negedge clk);
        check("R9 falling count", got[0], sent[0]);
        check("R9 falling held", dsc_temp, 60000);

        push(1'b1, 140, "R9 rising first");
        @(negedge clk); drive(1'b1, 140, 1'b1);
        @(negedge clk); drive(1'b1, 0, 1'b0);
        repeat (10) @(negedge clk);
        drive(1'b1, 1023, 1'b1);
        @(negedge clk); drive(1'b1, 0, 1'b0);
        wait_drain(1'b1);
        repeat (50) @(negedge clk);
        check("R9 rising count", got[1], sent[1]);
        check("R9 rising held", inc_temp, 45000);

        summary();
        $finish;
    end

endmodule